// File: doc/BRIEF.md
# ADC Wake-Up and Start Sequencer

This block controls the single enable bit of an analog-to-digital converter. One software-written bit carries two meanings. When the converter is powered down, setting the bit wakes it. It then waits out a stabilisation delay, counted in 1 MHz ticks, before it raises a ready flag that software polls. Once the converter is ready, setting the same bit again fires a one-clock conversion start pulse. Writing the bit as zero powers the converter down from any state.

The write strobe and the written value arrive together with the 1 MHz tick and the programmable stabilisation count. The block drives three outputs: an analog power enable, the ready flag and the start pulse. It does not perform the conversion.

Top module: `adc_wake_seq`

## Requirements
- R1: After reset, pwr_en, ready and conv_start are all 0.
- R2: A write of 1 (on_wr=1, on_val=1) while powered down raises pwr_en at the next clock edge. It leaves ready and conv_start at 0.
- R3: stab_cnt is sampled as N at the waking write. ready rises at the clock edge that follows the edge accepting the Nth tick_1m. With N=0, ready rises at the second edge after the waking write.
- R4: A change of stab_cnt after the waking write has no effect on when ready rises.
- R5: A write of 1 while stabilising is ignored. It produces no conv_start and does not shift the rise of ready.
- R6: A write of 1 while ready and not pulsing raises conv_start for exactly one clock. ready stays 1 throughout.
- R7: A write of 0 (on_wr=1, on_val=0) in any state drives pwr_en, ready and conv_start to 0 at the next edge. The same write while already powered down keeps them at 0.
- R8: A write of 1 during the conv_start cycle is ignored, so the pulse ends after one clock. tick_1m has no effect outside stabilisation.
- R9: ready is 1 only while pwr_en is 1, and conv_start is 1 only while ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| on_wr | input | 1 | Write strobe for the enable bit |
| on_val | input | 1 | Value written to the enable bit |
| tick_1m | input | 1 | One-clock pulse at 1 MHz |
| stab_cnt | input | CNT_W | Stabilisation delay in 1 MHz ticks |
| pwr_en | output | 1 | Analog power enable |
| ready | output | 1 | Converter stabilised and usable |
| conv_start | output | 1 | One-clock conversion start pulse |

## Verification
Every output is decoded directly from the state register. A wrong state therefore shows at the ports at the same edge that takes it. A wrong stabilisation count is hidden until it moves the rise of ready earlier or later than the Nth accepted tick. The bench compares all three outputs against a behavioural model after every clock. This catches a misplaced ready edge, a missing, doubled or stray start pulse, and a failure to power down within one cycle.

// File: rtl/adc_wake_seq.sv
module adc_wake_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             on_wr,
  input  logic             on_val,
  input  logic             tick_1m,
  input  logic [CNT_W-1:0] stab_cnt,
  output logic             pwr_en,
  output logic             ready,
  output logic             conv_start
);
  typedef enum logic [1:0] {S_OFF, S_STAB, S_READY, S_START} st_t;

  st_t              st, st_nx;
  logic [CNT_W-1:0] remain;

  wire set_on = on_wr & on_val;
  wire clr_on = on_wr & ~on_val;

  always_comb begin
    st_nx = st;
    unique case (st)
      S_OFF:   if (set_on) st_nx = S_STAB;
      S_STAB:  if (remain == '0) st_nx = S_READY;
      S_READY: if (set_on) st_nx = S_START;
      S_START: st_nx = S_READY;
      default: st_nx = S_OFF;
    endcase
    if (clr_on) st_nx = S_OFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_OFF;
      remain <= '0;
    end else begin
      st <= st_nx;
      if (st == S_OFF && set_on)
        remain <= stab_cnt;
      else if (st == S_STAB && tick_1m && remain != '0)
        remain <= remain - 1'b1;
    end
  end

  assign pwr_en     = (st != S_OFF);
  assign ready      = (st == S_READY) || (st == S_START);
  assign conv_start = (st == S_START);
endmodule

// File: rtl/adc_wake_seq_chk.sv
module adc_wake_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic on_wr,
  input logic on_val,
  input logic pwr_en,
  input logic ready,
  input logic conv_start
);
  a_r9_ready_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> pwr_en);
  a_r9_start_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> ready);
  a_r2_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en && on_wr && on_val) |=> (pwr_en && !ready && !conv_start));
  a_r5_ignore_while_stab: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && !ready && on_wr && on_val) |=> !conv_start);
  a_r6_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !conv_start && on_wr && on_val) |=> (conv_start && ready));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !(on_wr && !on_val)) |=> (!conv_start && ready));
  a_r7_power_down: assert property (@(posedge clk) disable iff (!rst_n)
    (on_wr && !on_val) |=> (!pwr_en && !ready && !conv_start));
endmodule

bind adc_wake_seq adc_wake_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .on_wr(on_wr), .on_val(on_val),
  .pwr_en(pwr_en), .ready(ready), .conv_start(conv_start)
);

// File: tb/adc_wake_seq_tb_top.sv
`timescale 1ns/1ps
module adc_wake_seq_tb_top;
  localparam int CNT_W = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic on_wr = 0, on_val = 0, tick_1m = 0;
  logic [CNT_W-1:0] stab_cnt = '0;
  logic pwr_en, ready, conv_start;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adc_wake_seq #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .on_wr(on_wr), .on_val(on_val),
    .tick_1m(tick_1m), .stab_cnt(stab_cnt),
    .pwr_en(pwr_en), .ready(ready), .conv_start(conv_start)
  );

  // Behavioural reference: 0 off, 1 stabilising, 2 ready, 3 start
  int m_st = 0;
  int m_rem = 0;

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_rem = 0;
    end else if (on_wr && !on_val) begin
      m_st = 0;
    end else begin
      case (m_st)
        0: if (on_wr && on_val) begin m_st = 1; m_rem = int'(stab_cnt); end
        1: if (m_rem == 0) m_st = 2; else if (tick_1m) m_rem--;
        2: if (on_wr && on_val) m_st = 3;
        default: m_st = 2;
      endcase
    end
    #1;
    check("R9 model pwr_en", pwr_en, m_st != 0);
    check("R9 model ready", ready, m_st >= 2);
    check("R9 model conv_start", conv_start, m_st == 3);
  end

  task automatic cyc(input logic w, input logic v, input logic t);
    on_wr = w; on_val = v; tick_1m = t;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    stab_cnt = 16'd3;
    repeat (3) @(negedge clk);
    check("R1 pwr_en", pwr_en, 0);
    check("R1 ready", ready, 0);
    check("R1 conv_start", conv_start, 0);
    rst_n = 1;
    cyc(1, 1, 0);
    check("R2 pwr_en", pwr_en, 1);
    check("R2 ready", ready, 0);
    cyc(0, 0, 1);
    cyc(1, 1, 0);
    check("R5 no start while stab", conv_start, 0);
    check("R5 not ready", ready, 0);
    cyc(0, 0, 1);
    stab_cnt = 16'd50;
    cyc(0, 0, 1);
    check("R3 not yet ready after Nth tick edge", ready, 0);
    cyc(0, 0, 0);
    check("R3 ready after Nth tick", ready, 1);
    check("R4 count change ignored", ready, 1);
    cyc(0, 0, 1);
    check("R8 tick in ready", conv_start, 0);
    cyc(1, 1, 0);
    check("R6 start pulse", conv_start, 1);
    check("R6 ready kept", ready, 1);
    cyc(1, 1, 0);
    check("R8 pulse one clock", conv_start, 0);
    check("R8 ready", ready, 1);
    cyc(1, 1, 0);
    check("R6 second start", conv_start, 1);
    cyc(1, 0, 0);
    check("R7 off from start pwr_en", pwr_en, 0);
    check("R7 off from start ready", ready, 0);
    check("R7 off from start conv_start", conv_start, 0);
    cyc(1, 0, 0);
    check("R7 stay off", pwr_en, 0);
    cyc(0, 0, 1);
    check("R8 tick while off", pwr_en, 0);
    stab_cnt = 16'd0;
    cyc(1, 1, 0);
    check("R3 zero count stab", ready, 0);
    cyc(0, 0, 0);
    check("R3 zero count ready", ready, 1);
    cyc(1, 0, 0);
    stab_cnt = 16'd5;
    cyc(1, 1, 0);
    cyc(1, 0, 1);
    check("R7 off from stab", pwr_en, 0);
    cyc(0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 15));
      if (r == 0) stab_cnt = 16'($urandom_range(0, 6));
      cyc(r < 3, r != 1, $urandom_range(0, 2) == 0);
    end
    cyc(0, 0, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule